// File: doc/BRIEF.md
# Vector Element Slide Unit

This block moves the elements of one vector register group up or down by a scalar distance and writes the resulting destination group. It supports three operations. Slide-up shifts source elements toward higher indices. Slide-down shifts them toward lower indices. Slide-up-by-one shifts by a single position and places a scalar value in element 0. Masking, a start index, the active length and tail clearing all apply to every operation. The element width can be 8, 16, 32 or 64 bits.

A request is taken on a single `start` cycle. On that cycle the block captures the source group, the old destination group, the mask group, the scalar, the operation controls and the lengths. It then visits one element index per clock, from 0 up to the last index below the maximum element count, and updates an internal destination register. `vdNew` shows that register. A one-cycle `done` pulse marks completion. The maximum element count is the register length divided by the element width. When the active length is zero, the block completes at once and changes nothing.

Top module: `slide_unit`

## Requirements
- R1: For slide-up (`op`=0, and the reserved code 3), an element whose index is below the larger of `vstart` and the offset keeps its old value. For all operations, an element whose index is below `vstart` keeps its old value.
- R2: For slide-up, an element i with max(`vstart`, offset) ≤ i < `vl` is active when `vm`=1 or mask bit i is set. Mask bit i is bit i·SEW of `v0`. An active element receives source element i − offset. An inactive element keeps its old value.
- R3: Every element with `vl` ≤ i < VLMAX is written with zero. This includes slide-up elements with index at or above `vl` when the offset exceeds `vl`.
- R4: With `vl`=0, `vdNew` equals the captured `vdOld`. Nothing is written, the tail included, and `done` rises in the cycle after the start edge.
- R5: The offset is compared at its full 64-bit width, with no truncation. An offset whose low bits are small but whose upper bits are set behaves as a huge offset.
- R6: For slide-down (`op`=1), an active element i < `vl` receives source element i + offset when i + offset < VLMAX. Otherwise it receives zero, so an offset ≥ VLMAX zeroes every active body element.
- R7: For slide-up-by-one (`op`=2), an active element 0 receives the scalar truncated to SEW bits. An active element i > 0 receives source element i − 1.
- R8: `sew` codes 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements. VLMAX = VLEN/SEW. With `vl` > 0, `done` rises VLMAX+1 clock edges after the start edge, counting the start edge itself.
- R9: `done` is a single-cycle pulse and is never high together with `busy`. After reset, `busy` and `done` are low, and `vdNew` changes only while a request is running or being accepted.
- R10: A `start` asserted while `busy` is high is ignored. The running operation's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when idle |
| op | input | 2 | 0 slide-up, 1 slide-down, 2 slide-up-by-one, 3 as slide-up |
| vm | input | 1 | 1 disables masking |
| sew | input | 2 | Element width code (8 << sew bits) |
| vl | input | CNTW | Active element count, at most VLMAX |
| vstart | input | CNTW | First element index to process |
| scalar | input | XLEN | Offset, or the insert value for slide-up-by-one |
| vs2 | input | VLEN | Source vector group |
| vdOld | input | VLEN | Old destination contents |
| v0 | input | VLEN | Mask group |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vdNew | output | VLEN | New destination contents |

## Verification
The bench sweeps every operation and every element width. It uses every `vl` from zero to VLMAX, start indices of 0 and 2, both `vm` settings and random masks. Offsets are chosen to straddle each boundary: 0, 1 to 3, exactly `vl`, VLMAX−1, VLMAX, beyond VLMAX, and a value with only the top bit and bit 0 set. The first groups separate kept prefixes from moved bodies. Offsets above `vl` separate tail clearing from keeping old values. Offsets at and beyond VLMAX separate zeroed slide-down reads from wrapped reads. The top-bit offset separates a full-width compare from a truncated one. Some runs inject a second `start` mid-operation with different controls and expect the original result and completion cycle.

// File: rtl/slide_pkg.sv
package slide_pkg;
  typedef enum logic [1:0] {
    OP_UP   = 2'd0,
    OP_DOWN = 2'd1,
    OP_UP1  = 2'd2,
    OP_RSV  = 2'd3
  } slideOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture operands and old destination
    logic step;  // process element at the current index
  } slideStb_t;
endpackage

// File: rtl/slide_ctrl.sv
module slide_ctrl
  import slide_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int MAXEL = VLEN / 8,
  localparam int IDXW = $clog2(MAXEL),
  localparam int CNTW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      sew,
  input  logic [CNTW-1:0] vl,
  output slideStb_t       stb,
  output logic [IDXW-1:0] idx,
  output logic            busy,
  output logic            done
);
  logic [IDXW-1:0] idxQ, lastQ;
  logic            busyQ, doneQ;
  logic [CNTW-1:0] vlmaxIn;

  assign vlmaxIn  = CNTW'(MAXEL) >> sew;
  assign stb.load = start && !busyQ;
  assign stb.step = busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      lastQ <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (stb.load) begin
        idxQ  <= '0;
        lastQ <= IDXW'(vlmaxIn - CNTW'(1));
        busyQ <= (vl != '0);
        doneQ <= (vl == '0);
      end else if (busyQ) begin
        if (idxQ == lastQ) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          idxQ <= idxQ + IDXW'(1);
        end
      end
    end
  end

  assign idx  = idxQ;
  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/slide_dp.sv
module slide_dp
  import slide_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  localparam int MAXEL = VLEN / 8,
  localparam int IDXW = $clog2(MAXEL),
  localparam int CNTW = IDXW + 1,
  localparam int BW = $clog2(VLEN),
  localparam int ELW = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  slideStb_t       stb,
  input  logic [IDXW-1:0] idx,
  input  logic [1:0]      op,
  input  logic            vm,
  input  logic [1:0]      sew,
  input  logic [CNTW-1:0] vl,
  input  logic [CNTW-1:0] vstart,
  input  logic [XLEN-1:0] scalar,
  input  logic [VLEN-1:0] vs2,
  input  logic [VLEN-1:0] vdOld,
  input  logic [VLEN-1:0] v0,
  output logic [VLEN-1:0] vdNew
);
  slideOp_e        opQ;
  logic            vmQ;
  logic [1:0]      sewQ;
  logic [CNTW-1:0] vlQ, vstartQ;
  logic [XLEN-1:0] scalarQ;
  logic [VLEN-1:0] vs2Q, v0Q, resQ;

  logic [2:0]      lgEb;
  logic [CNTW-1:0] vlmax;
  logic [ELW-1:0]  elemMask, srcVal, insVal, wrVal;
  logic [XLEN:0]   downSum;
  logic [IDXW-1:0] srcIdx;
  logic [BW-1:0]   srcBase, wrBase;
  logic            keep, useIns, zeroIt, inBody, active, doWrite;

  assign lgEb     = 3'd3 + {1'b0, sewQ};
  assign vlmax    = CNTW'(MAXEL) >> sewQ;
  assign elemMask = (sewQ == 2'd3) ? '1 : ((ELW'(1) << (7'd8 << sewQ)) - ELW'(1));
  assign insVal   = ELW'(scalarQ) & elemMask;
  assign downSum  = {1'b0, scalarQ} + (XLEN+1)'(idx);

  // source element selection per operation, full-width offset compares
  always_comb begin
    srcIdx = idx;
    keep   = 1'b0;
    useIns = 1'b0;
    zeroIt = 1'b0;
    case (opQ)
      OP_DOWN: begin
        if (downSum < (XLEN+1)'(vlmax)) srcIdx = idx + IDXW'(scalarQ);
        else zeroIt = 1'b0 | 1'b1;
      end
      OP_UP1: begin
        if (idx == '0) useIns = 1'b1;
        else srcIdx = idx - IDXW'(1);
      end
      default: begin
        if (XLEN'(idx) < scalarQ) keep = 1'b1;
        else srcIdx = idx - IDXW'(scalarQ);
      end
    endcase
  end

  assign srcBase = BW'(srcIdx) << lgEb;
  assign wrBase  = BW'(idx) << lgEb;
  assign srcVal  = ELW'(vs2Q >> srcBase) & elemMask;
  assign inBody  = CNTW'(idx) < vlQ;
  assign active  = vmQ || v0Q[wrBase];

  always_comb begin
    doWrite = 1'b0;
    wrVal   = '0;
    if (!inBody) begin
      doWrite = 1'b1;
    end else if (CNTW'(idx) >= vstartQ && active && !keep) begin
      doWrite = 1'b1;
      wrVal   = useIns ? insVal : (zeroIt ? '0 : srcVal);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ     <= OP_UP;
      vmQ     <= 1'b0;
      sewQ    <= '0;
      vlQ     <= '0;
      vstartQ <= '0;
      scalarQ <= '0;
      vs2Q    <= '0;
      v0Q     <= '0;
      resQ    <= '0;
    end else if (stb.load) begin
      opQ     <= slideOp_e'(op);
      vmQ     <= vm;
      sewQ    <= sew;
      vlQ     <= vl;
      vstartQ <= vstart;
      scalarQ <= scalar;
      vs2Q    <= vs2;
      v0Q     <= v0;
      resQ    <= vdOld;
    end else if (stb.step && doWrite) begin
      resQ <= (resQ & ~(VLEN'(elemMask) << wrBase)) | (VLEN'(wrVal) << wrBase);
    end
  end

  assign vdNew = resQ;
endmodule

// File: rtl/slide_unit.sv
module slide_unit
  import slide_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  localparam int CNTW = $clog2(VLEN / 8) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic            vm,
  input  logic [1:0]      sew,
  input  logic [CNTW-1:0] vl,
  input  logic [CNTW-1:0] vstart,
  input  logic [XLEN-1:0] scalar,
  input  logic [VLEN-1:0] vs2,
  input  logic [VLEN-1:0] vdOld,
  input  logic [VLEN-1:0] v0,
  output logic            busy,
  output logic            done,
  output logic [VLEN-1:0] vdNew
);
  localparam int IDXW = CNTW - 1;

  slideStb_t       stb;
  logic [IDXW-1:0] idx;

  slide_ctrl #(.VLEN(VLEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sew(sew), .vl(vl),
    .stb(stb), .idx(idx), .busy(busy), .done(done)
  );

  slide_dp #(.VLEN(VLEN), .XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .op(op), .vm(vm),
    .sew(sew), .vl(vl), .vstart(vstart), .scalar(scalar), .vs2(vs2),
    .vdOld(vdOld), .v0(v0), .vdNew(vdNew)
  );
endmodule

// File: rtl/slide_unit_chk.sv
module slide_unit_chk #(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  localparam int CNTW = $clog2(VLEN / 8) + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [CNTW-1:0] vl,
  input logic [VLEN-1:0] vdOld,
  input logic            busy,
  input logic            done,
  input logic [VLEN-1:0] vdNew
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9
  AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(vdNew)); // R9
  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && vl == '0) |=> (done && !busy)); // R4
  AST_ZERO_LEN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && vl == '0) |=> (vdNew == $past(vdOld))); // R4
endmodule

bind slide_unit slide_unit_chk #(.VLEN(VLEN), .XLEN(XLEN)) u_chk (.*);

// File: tb/slide_unit_tb.sv
module slide_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN = 128;
  localparam int XLEN = 64;
  localparam int CNTW = $clog2(VLEN / 8) + 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      op = '0;
  logic            vm = 1'b0;
  logic [1:0]      sew = '0;
  logic [CNTW-1:0] vl = '0, vstart = '0;
  logic [XLEN-1:0] scalar = '0;
  logic [VLEN-1:0] vs2 = '0, vdOld = '0, v0 = '0;
  logic            busy, done;
  logic [VLEN-1:0] vdNew;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  slide_unit #(.VLEN(VLEN), .XLEN(XLEN)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 190000", cyc);
      finishRun();
    end
  end

  function automatic logic [63:0] nextRand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  function automatic logic [VLEN-1:0] randVec();
    logic [VLEN-1:0] r = '0;
    for (int k = 0; k < VLEN / 64; k++) r = (r << 64) | VLEN'(nextRand());
    return r;
  endfunction

  // reference result computed from the requirements
  function automatic logic [VLEN-1:0] model(int opI, bit vmF, int sw, int vlI, int vsI,
      logic [63:0] sc, logic [VLEN-1:0] s2, logic [VLEN-1:0] od, logic [VLEN-1:0] m0);
    int eb = 8 << sw;
    int vmax = VLEN / eb;
    logic [63:0] em = (eb == 64) ? '1 : ((64'd1 << eb) - 64'd1);
    logic [VLEN-1:0] r = od;
    if (vlI == 0) return od;
    for (int i = 0; i < vmax; i++) begin
      logic [63:0] nv;
      nv = 64'(od >> (i * eb)) & em;
      if (i >= vlI) nv = '0;
      else if (i >= vsI && (vmF || m0[i * eb])) begin
        if (opI == 1) begin
          if (sc >= 64'(vmax) || 64'(i) + sc >= 64'(vmax)) nv = '0;
          else nv = 64'(s2 >> ((i + int'(sc)) * eb)) & em;
        end else if (opI == 2) begin
          nv = (i == 0) ? (sc & em) : (64'(s2 >> ((i - 1) * eb)) & em);
        end else begin
          if (sc <= 64'(i)) nv = 64'(s2 >> ((i - int'(sc)) * eb)) & em;
        end
      end
      r = (r & ~(VLEN'(em) << (i * eb))) | (VLEN'(nv) << (i * eb));
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOne(int opI, bit vmF, int sw, int vlI, int vsI, logic [63:0] sc, bit poke);
    logic [VLEN-1:0] exp;
    int n;
    int vmax = VLEN / (8 << sw);
    int expLat = (vlI == 0) ? 1 : vmax + 1;
    string tag;
    @(negedge clk);
    op = 2'(opI); vm = vmF; sew = 2'(sw); vl = CNTW'(vlI); vstart = CNTW'(vsI);
    scalar = sc; vs2 = randVec(); vdOld = randVec(); v0 = randVec();
    exp = model(opI, vmF, sw, vlI, vsI, sc, vs2, vdOld, v0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 300) begin
      if (poke && n == 2) begin
        start = 1'b1; op = 2'(opI ^ 1); vl = '0; vs2 = ~vs2; vdOld = ~vdOld;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    if (vlI == 0) tag = "R4";
    else if (poke) tag = "R10";
    else if (sc[63]) tag = "R5";
    else if (opI == 1) tag = "R6";
    else if (opI == 2) tag = "R7";
    else if (sc > 64'(vlI)) tag = "R3";
    else if (vsI > 0) tag = "R1";
    else tag = "R2";
    check(vdNew == exp, tag, vdNew, exp);
    check(n == expLat, (vlI == 0) ? "R4 latency" : (poke ? "R10 latency" : "R8 latency"),
          VLEN'(n), VLEN'(expLat));
    @(negedge clk);
    check(!done && !busy, "R9 done pulse", VLEN'({done, busy}), '0);
  endtask

  initial begin
    logic [63:0] offs [9];
    repeat (3) @(negedge clk);
    check(!busy && !done, "R9 reset busy/done", VLEN'({busy, done}), '0);
    check(vdNew == '0, "R9 reset result", vdNew, '0);
    rstN = 1'b1;
    for (int sw = 0; sw < 4; sw++) begin
      int vmax = VLEN / (8 << sw);
      for (int vlI = 0; vlI <= vmax; vlI++) begin
        offs[0] = 0; offs[1] = 1; offs[2] = 2; offs[3] = 3; offs[4] = 64'(vlI);
        offs[5] = 64'(vmax - 1); offs[6] = 64'(vmax); offs[7] = 64'(vmax + 5);
        offs[8] = 64'h8000_0000_0000_0001;
        for (int opI = 0; opI < 3; opI++)
          for (int k = 0; k < 9; k++)
            for (int vmI = 0; vmI < 2; vmI++)
              for (int vsI = 0; vsI <= 2; vsI += 2)
                runOne(opI, bit'(vmI), sw, vlI, vsI, offs[k],
                       (k == 1 && vmI == 1 && vsI == 0 && vlI > 0));
      end
    end
    finishRun();
  end
endmodule